// File: doc/BRIEF.md
# Page-mode DRAM controller

This block takes flat word addresses from a requester and turns them into strobe sequences for a dynamic memory with 64 rows and 64 columns of one bit each. The address is split into two halves. The row half goes out on a shared address bus while an active-low row strobe falls. This opens the row, and the memory copies the whole row into its sense latches. The column half then goes out while an active-low column strobe falls, and that picks one latched bit.

After a row has been opened it stays open. A later request to the same row needs only another column strobe, with no new cell access. A read may ask for several words. The controller then steps an internal column counter and issues one column strobe per word, all within the single row activation. Reading destroys the stored row, so the row must be written back before another row can open. For this reason a request to a different row first raises the row strobe for a precharge time set by a parameter. The delay from row strobe to first column strobe is also a parameter.

Requests arrive on a valid/ready handshake. Back-pressure rules: `req_ready` is high only while no access is in progress. The requester must hold all request fields steady while `req_valid` is high and `req_ready` is low. A request is taken on a rising edge where both are high. Read data comes back as single-cycle `rsp_valid` pulses, in request order. There is no back-pressure on the response side.

Top module: `page_dram_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, both strobes and `dram_wr_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: The row is `req_addr[11:6]` and the column is `req_addr[5:0]`. The row appears on `dram_a` when the row strobe falls, and the column appears on `dram_a` when each column strobe falls.
- R3: After the row strobe falls, the column strobe stays high for exactly T_RCD cycles with the row strobe low. The first column strobe falls after that.
- R4: A request to the row that is already open causes no new row strobe. Its column strobe is low in the first cycle after acceptance. For a read, `rsp_valid` is high in the second cycle after acceptance.
- R5: A read with `req_len` = N returns N words from consecutive columns under one row activation (N = 0 counts as 1). Each column strobe is low for one cycle, and the column strobes are separated by one high cycle.
- R6: A burst ends after column 63 and does not carry into the next row. A read that starts at column c returns min(N, 64 - c) words.
- R7: A request to a row other than the open one holds the row strobe high for exactly T_RP cycles before the row strobe falls for the new row.
- R8: A write (`req_we` = 1) drives `dram_wr_n` low and `dram_d` = `req_wdata` during one column strobe, whatever the value of `req_len`. A write produces no response, and later reads of that bit return the written value.
- R9: `req_ready` is low while an access is in progress. A held request is served once the controller is idle. Responses arrive in request order, with no response that was not asked for.
- R10: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 12 | Word address: row in the high half, column in the low half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write data bit |
| req_len | input | 7 | Read burst length in words (0 counts as 1) |
| rsp_valid | output | 1 | Read data valid, one cycle per word |
| rsp_data | output | 1 | Read data bit |
| dram_row_stb_n | output | 1 | Row strobe, active low |
| dram_col_stb_n | output | 1 | Column strobe, active low |
| dram_wr_n | output | 1 | Write enable to the memory, active low |
| dram_a | output | 6 | Multiplexed row/column address |
| dram_d | output | 1 | Data to the memory |
| dram_q | input | 1 | Data from the memory |

## Verification
The bench first applies a single cold read, which checks the address split and the row-to-column delay. Next come same-row reads at scattered columns, which separate a true page hit (no new row strobe, two-cycle latency) from a controller that reopens the row on every access. Bursts are run in the middle of a row and at its top edge, to tell apart column stepping, the stop at column 63 and the length-zero case. Finally a row change, writes with long lengths, and a mixed pseudo-random stream across a few rows check the precharge time, the single-column write and the write-back of the sense latches into the array.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_ROW_ACTIVE = 2'd1,
    ST_COL_ACCESS = 2'd2,
    ST_PRECHARGE  = 2'd3
  } dpc_state_e;
endpackage

// File: rtl/dpc_wait_timer.sv
// Down counter: loaded with a cycle count, reports when it has reached zero.
module dpc_wait_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dpc_burst_ctr.sv
// Column stepper for bursts; "last" marks the final word or the top column.
module dpc_burst_ctr #(
  parameter int COL_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             last
);
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      left <= LEN_W'(1);
    end else if (load) begin
      col  <= load_col;
      left <= (load_len == '0) ? LEN_W'(1) : load_len;
    end else if (step) begin
      col  <= col + 1'b1;
      left <= left - 1'b1;
    end
  end

  assign last = (left <= LEN_W'(1)) || (col == '1);
endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int LEN_W = 7,
  parameter int T_RCD = 2,
  parameter int T_RP  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic                   req_wdata,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   rsp_valid,
  output logic                   rsp_data,
  output logic                   dram_row_stb_n,
  output logic                   dram_col_stb_n,
  output logic                   dram_wr_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                   dram_d,
  input  logic                   dram_q
);
  localparam int A_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_W   = $clog2(T_MAX + 1);

  dpc_state_e       st;
  logic [ROW_W-1:0] open_row;
  logic             row_open;
  logic             gap;
  logic             pend_we;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             accept, hit;

  logic             tmr_load, tmr_expired;
  logic [T_W-1:0]   tmr_val;
  logic             bc_step, bc_last;
  logic [COL_W-1:0] bc_col;
  logic [LEN_W-1:0] bc_len;

  assign req_row   = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = row_open && (req_row == open_row);
  assign bc_len    = req_we ? LEN_W'(1) : req_len;
  assign bc_step   = (st == ST_COL_ACCESS) && !gap && !bc_last;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = T_W'(T_RCD - 1);
    if (st == ST_IDLE && accept && !hit) begin
      tmr_load = 1'b1;
      tmr_val  = row_open ? T_W'(T_RP - 1) : T_W'(T_RCD - 1);
    end else if (st == ST_PRECHARGE && tmr_expired) begin
      tmr_load = 1'b1;
    end
  end

  dpc_wait_timer #(.W(T_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dpc_burst_ctr #(.COL_W(COL_W), .LEN_W(LEN_W)) i_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_col (req_col),
    .load_len (bc_len),
    .step     (bc_step),
    .col      (bc_col),
    .last     (bc_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      open_row       <= '0;
      row_open       <= 1'b0;
      gap            <= 1'b0;
      pend_we        <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_data       <= 1'b0;
      dram_row_stb_n <= 1'b1;
      dram_col_stb_n <= 1'b1;
      dram_wr_n      <= 1'b1;
      dram_a         <= '0;
      dram_d         <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            pend_we  <= req_we;
            dram_d   <= req_wdata;
            open_row <= req_row;
            if (hit) begin
              dram_col_stb_n <= 1'b0;
              dram_wr_n      <= ~req_we;
              dram_a         <= A_W'(req_col);
              gap            <= 1'b0;
              st             <= ST_COL_ACCESS;
            end else if (row_open) begin
              dram_row_stb_n <= 1'b1;
              row_open       <= 1'b0;
              st             <= ST_PRECHARGE;
            end else begin
              dram_row_stb_n <= 1'b0;
              dram_a         <= A_W'(req_row);
              row_open       <= 1'b1;
              st             <= ST_ROW_ACTIVE;
            end
          end
        end
        ST_PRECHARGE: begin
          if (tmr_expired) begin
            dram_row_stb_n <= 1'b0;
            dram_a         <= A_W'(open_row);
            row_open       <= 1'b1;
            st             <= ST_ROW_ACTIVE;
          end
        end
        ST_ROW_ACTIVE: begin
          if (tmr_expired) begin
            dram_col_stb_n <= 1'b0;
            dram_wr_n      <= ~pend_we;
            dram_a         <= A_W'(bc_col);
            gap            <= 1'b0;
            st             <= ST_COL_ACCESS;
          end
        end
        ST_COL_ACCESS: begin
          if (!gap) begin
            dram_col_stb_n <= 1'b1;
            dram_wr_n      <= 1'b1;
            if (!pend_we) begin
              rsp_valid <= 1'b1;
              rsp_data  <= dram_q;
            end
            if (bc_last) st  <= ST_IDLE;
            else         gap <= 1'b1;
          end else begin
            dram_col_stb_n <= 1'b0;
            dram_a         <= A_W'(bc_col);
            gap            <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int T_RP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic row_stb_n,
  input logic col_stb_n
);
  localparam int CW = $clog2(T_RP + 1) + 1;
  logic [CW-1:0] hi_cnt;

  // Cycles the row strobe has been high, saturating at T_RP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= CW'(T_RP);
    else if (!row_stb_n)     hi_cnt <= '0;
    else if (hi_cnt < CW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |-> !row_stb_n);                                   // R10
  AST_COL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |=> col_stb_n);                                    // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |-> !req_ready);                                   // R9
  AST_RSP_AFTER_COL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!col_stb_n));                             // R4
  AST_ROW_OPENS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> col_stb_n);                              // R3
  AST_PRECHARGE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> (hi_cnt >= CW'(T_RP)));                  // R7
endmodule

bind page_dram_ctrl dpc_checker #(.T_RP(T_RP)) i_dpc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .row_stb_n (dram_row_stb_n),
  .col_stb_n (dram_col_stb_n)
);

// File: tb/test_page_dram_ctrl.sv
module test_page_dram_ctrl;
  localparam int T_RCD = 2;
  localparam int T_RP  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [11:0] req_addr = '0;
  logic       req_we = 1'b0;
  logic       req_wdata = 1'b0;
  logic [6:0] req_len = '0;
  logic       rsp_valid, rsp_data;
  logic       dram_row_stb_n, dram_col_stb_n, dram_wr_n, dram_d, dram_q;
  logic [5:0] dram_a;

  always #4 clk = ~clk;

  page_dram_ctrl #(.T_RCD(T_RCD), .T_RP(T_RP)) i_page_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dram_row_stb_n(dram_row_stb_n), .dram_col_stb_n(dram_col_stb_n),
    .dram_wr_n(dram_wr_n), .dram_a(dram_a), .dram_d(dram_d), .dram_q(dram_q)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int i);
    logic [11:0] a;
    a = 12'(i);
    return (^(a & 12'hA93)) ^ (a[4] & a[9]);
  endfunction

  // Behavioural memory: array, sense latches, destructive open and write-back.
  logic arr [4096];
  logic shd [4096];
  logic sense [64];
  bit   m_open = 0;
  int   m_row = 0;

  initial for (int i = 0; i < 4096; i++) begin arr[i] = pat(i); shd[i] = pat(i); end

  always @(posedge clk) begin
    if (!dram_row_stb_n && !m_open) begin
      m_open = 1;
      m_row  = int'(dram_a);
      for (int k = 0; k < 64; k++) begin sense[k] = arr[m_row*64+k]; arr[m_row*64+k] = 1'bx; end
    end else if (dram_row_stb_n && m_open) begin
      for (int k = 0; k < 64; k++) arr[m_row*64+k] = sense[k];
      m_open = 0;
    end
    if (m_open && !dram_col_stb_n && !dram_wr_n) sense[dram_a] = dram_d;
  end

  assign dram_q = (m_open && !dram_col_stb_n) ? sense[dram_a] : 1'b0;

  // Per-clock reference compare.
  logic exp_q[$];
  int  act_cnt = 0, rsp_cnt = 0, hi_cnt = 0, rcd_cnt = 0;
  int  last_row = -1, last_col = -1;
  bit  prev_row = 1, prev_col = 1, had_open = 0, want_first = 0;

  always @(negedge clk) if (rst_n) begin
    if (!dram_row_stb_n && prev_row) begin
      act_cnt++;
      last_row = int'(dram_a);
      if (had_open) chk(hi_cnt == T_RP, "R7 precharge cycles", hi_cnt, T_RP);
      rcd_cnt = 0;
      want_first = 1;
    end
    if (dram_row_stb_n) begin
      if (!prev_row) had_open = 1;
      hi_cnt = prev_row ? hi_cnt + 1 : 1;
    end
    if (!dram_row_stb_n && dram_col_stb_n && want_first) rcd_cnt++;
    if (!dram_col_stb_n && prev_col) begin
      last_col = int'(dram_a);
      if (want_first) chk(rcd_cnt == T_RCD, "R3 row-to-column cycles", rcd_cnt, T_RCD);
      want_first = 0;
    end
    if (rsp_valid) begin
      rsp_cnt++;
      if (exp_q.size() == 0) chk(0, "R9 unexpected response", 1, 0);
      else begin
        logic e;
        e = exp_q.pop_front();
        chk(rsp_data === e, "R5 read data", int'(rsp_data), int'(e));
      end
    end
    prev_row = dram_row_stb_n;
    prev_col = dram_col_stb_n;
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic do_req(input logic [11:0] addr, input logic we, input logic wd, input int len);
    int row, col, n;
    row = int'(addr[11:6]);
    col = int'(addr[5:0]);
    if (we) shd[row*64+col] = wd;
    else begin
      n = (len == 0) ? 1 : len;
      if (n > 64 - col) n = 64 - col;
      for (int k = 0; k < n; k++) exp_q.push_back(shd[row*64+col+k]);
    end
    req_addr = addr; req_we = we; req_wdata = wd; req_len = 7'(len);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a0, r0, seed;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dram_row_stb_n == 1, "R1 row strobe in reset", int'(dram_row_stb_n), 1);
    chk(dram_col_stb_n == 1, "R1 column strobe in reset", int'(dram_col_stb_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 no response after reset", int'(rsp_valid), 0);
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    chk(dram_wr_n == 1, "R1 write strobe after reset", int'(dram_wr_n), 1);

    // R2/R3: cold read of row 5, column 5
    do_req({6'd5, 6'd5}, 0, 0, 1);
    drain();
    chk(last_row == 5, "R2 row half on row strobe", last_row, 5);
    chk(last_col == 5, "R2 column half on column strobe", last_col, 5);

    // R4: page hits
    a0 = act_cnt;
    do_req({6'd5, 6'd20}, 0, 0, 1);
    chk(dram_col_stb_n == 0, "R4 column strobe one cycle after accept", int'(dram_col_stb_n), 0);
    @(negedge clk);
    chk(rsp_valid == 1, "R4 hit latency", int'(rsp_valid), 1);
    do_req({6'd5, 6'd63}, 0, 0, 0);
    do_req({6'd5, 6'd0}, 0, 0, 1);
    drain();
    chk(act_cnt == a0, "R4 no row strobe on hit", act_cnt, a0);

    // R5: burst of 8 from column 10
    r0 = rsp_cnt;
    do_req({6'd5, 6'd10}, 0, 0, 8);
    chk(req_ready == 0, "R9 not ready during burst", int'(req_ready), 0);
    drain();
    chk(rsp_cnt - r0 == 8, "R5 burst word count", rsp_cnt - r0, 8);
    chk(last_col == 17, "R5 burst last column", last_col, 17);
    chk(act_cnt == a0, "R5 single activation", act_cnt, a0);

    // R6: burst stops after column 63
    r0 = rsp_cnt;
    do_req({6'd5, 6'd62}, 0, 0, 5);
    drain();
    chk(rsp_cnt - r0 == 2, "R6 wrap ends burst", rsp_cnt - r0, 2);
    chk(last_col == 63, "R6 last column", last_col, 63);
    chk(last_row == 5, "R6 no row change", last_row, 5);

    // R7/R2: row change
    do_req({6'd40, 6'd3}, 0, 0, 1);
    drain();
    chk(act_cnt == a0 + 1, "R7 one new activation", act_cnt, a0 + 1);
    chk(last_row == 40, "R2 new row on row strobe", last_row, 40);

    // R8: write with long length touches one column, no response
    r0 = rsp_cnt;
    do_req({6'd40, 6'd7}, 1, ~shd[40*64+7], 6);
    drain();
    chk(rsp_cnt == r0, "R8 write has no response", rsp_cnt, r0);
    do_req({6'd40, 6'd6}, 0, 0, 4);
    do_req({6'd1, 6'd0}, 1, ~shd[64], 1);
    do_req({6'd40, 6'd7}, 0, 0, 1);
    do_req({6'd1, 6'd0}, 0, 0, 2);
    drain();
    chk(rsp_cnt - r0 == 7, "R8 read-back word count", rsp_cnt - r0, 7);

    // R9: mixed stream across four rows, back to back
    seed = 7;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] s;
      seed = seed * 1103515245 + 12345;
      s = 32'(seed);
      do_req({4'd0, s[17:16], s[13:8]}, s[22] & s[23], s[28], int'(s[27:25]));
    end
    drain();
    chk(exp_q.size() == 0, "R9 all responses returned", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule